// File: doc/BRIEF.md
# Cascaded Synchronous Presettable Counter

An 8-bit synchronous binary up counter built from two identical 4-bit counter slices. Each slice has an active-low synchronous clear, an active-low synchronous parallel load, and two count enables: a parallel enable and a chain enable. A slice advances by one only when both enables are high. Each slice drives a combinational terminal-carry output, which is high when the slice holds all ones and its chain enable is high.

The slices are linked by carry look-ahead. In the lowest slice, both enables come from the external count enable. In each higher slice, the chain enable is the terminal carry of the slice below it, and the parallel enable is tied high. All slices share one clock, so the whole value changes on a single edge.

The terminal carry of the top slice is the block's final carry output. Another counter of the same kind can use it as its chain enable.

Top module: `cascade_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, `count` becomes 0 after that edge, whatever the other inputs are.
- R2: Clear takes priority over load: with `clr_n` and `ld_n` both low, `count` becomes 0 and not `load_val`.
- R3: When `clr_n` is high and `ld_n` is low at a rising edge, `count` takes `load_val`.
- R4: Load takes priority over counting: a load with `cnt_en` high still gives exactly `load_val`, and this includes a load made while `count` is 255.
- R5: When `clr_n` and `ld_n` are high and `cnt_en` is high, `count` increases by one at each rising edge.
- R6: When `clr_n` and `ld_n` are high and `cnt_en` is low, `count` holds its value.
- R7: `term_carry` is combinational and is high exactly when `count` is 255 and `cnt_en` is high.
- R8: The upper four bits of `count` (bits 7:4) change during counting only on an edge where the lower four bits go from 15 to 0.
- R9: Counting wraps from 255 to 0.
- R10: Clear and load act only at a rising edge: while the clock is steady, changing `clr_n` or `ld_n` leaves `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| load_val | input | 8 | Value taken on a load |
| cnt_en | input | 1 | External count enable |
| count | output | 8 | Current count value |
| term_carry | output | 1 | High when count is 255 and cnt_en is high |

## Verification
Two pairs of operations can be requested on the same edge. Clear can coincide with load, and load can coincide with counting. The bench sets up both pairs on purpose: it drives `clr_n` and `ld_n` low together, and it applies a load with `cnt_en` high, including once while the count is 255 and the carry chain is fully active. In each case, the value after the edge must match only the higher-priority operation: 0 for the first pair and `load_val` for the second. The bench also moves the control inputs between edges and checks that `count` stays put until the next rising edge.

// File: rtl/cascnt_pkg.sv
package cascnt_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } slice_mode_e;

  // Resolve the slice controls in fixed priority: clear, then load, then count.
  function automatic slice_mode_e pick_mode(input logic clr_n, input logic ld_n,
                                            input logic en_par, input logic en_chain);
    if (!clr_n)                  return MODE_CLEAR;
    else if (!ld_n)              return MODE_LOAD;
    else if (en_par && en_chain) return MODE_COUNT;
    else                         return MODE_HOLD;
  endfunction

endpackage

// File: rtl/cascnt_slice_ctrl.sv
module cascnt_slice_ctrl
  import cascnt_pkg::*;
(
  input  logic        clr_n,
  input  logic        ld_n,
  input  logic        en_par,
  input  logic        en_chain,
  output slice_mode_e mode
);

  always_comb mode = pick_mode(clr_n, ld_n, en_par, en_chain);

endmodule

// File: rtl/cascnt_slice.sv
module cascnt_slice
  import cascnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_par,
  input  logic         en_chain,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);

  slice_mode_e mode;
  logic [W-1:0] q_r;

  cascnt_slice_ctrl u_ctrl (
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .en_par   (en_par),
    .en_chain (en_chain),
    .mode     (mode)
  );

  always_ff @(posedge clk) begin
    case (mode)
      MODE_CLEAR: q_r <= '0;
      MODE_LOAD:  q_r <= d;
      MODE_COUNT: q_r <= q_r + W'(1);
      default:    q_r <= q_r;
    endcase
  end

  assign q  = q_r;
  // Terminal carry: all ones, qualified by the chain enable only.
  assign tc = (&q_r) & en_chain;

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 2
) (
  input  logic                          clk,
  input  logic                          clr_n,
  input  logic                          ld_n,
  input  logic [SLICE_W*NUM_SLICES-1:0] load_val,
  input  logic                          cnt_en,
  output logic [SLICE_W*NUM_SLICES-1:0] count,
  output logic                          term_carry
);

  localparam int CNT_W = SLICE_W * NUM_SLICES;

  // Chain enable into each slice; entry NUM_SLICES is the final carry.
  logic [NUM_SLICES:0]   chain_en;
  logic [NUM_SLICES-1:0] par_en;
  logic [CNT_W-1:0]      count_w;

  assign chain_en[0] = cnt_en;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    if (i == 0) begin : g_low
      assign par_en[i] = cnt_en;
    end else begin : g_high
      assign par_en[i] = 1'b1;
    end

    cascnt_slice #(.W(SLICE_W)) u_slice (
      .clk      (clk),
      .clr_n    (clr_n),
      .ld_n     (ld_n),
      .en_par   (par_en[i]),
      .en_chain (chain_en[i]),
      .d        (load_val[i*SLICE_W +: SLICE_W]),
      .q        (count_w[i*SLICE_W +: SLICE_W]),
      .tc       (chain_en[i+1])
    );
  end

  assign count      = count_w;
  assign term_carry = chain_en[NUM_SLICES];

endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int CNT_W   = 8,
  parameter int SLICE_W = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             ld_n,
  input logic [CNT_W-1:0] load_val,
  input logic             cnt_en,
  input logic [CNT_W-1:0] count,
  input logic             term_carry
);

  // Checks start once a clear has defined the state.
  logic started_q = 1'b0;
  always_ff @(posedge clk) if (!clr_n) started_q <= 1'b1;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!started_q)
    !clr_n |=> count == '0); // R1 R2

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!started_q)
    (clr_n && !ld_n) |=> count == $past(load_val)); // R3 R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!started_q)
    (clr_n && ld_n && cnt_en) |=> count == CNT_W'($past(count) + 1'b1)); // R5 R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!started_q)
    (clr_n && ld_n && !cnt_en) |=> $stable(count)); // R6

  AST_CARRY_OUT: assert property (@(posedge clk) disable iff (!started_q)
    term_carry == ((count == {CNT_W{1'b1}}) && cnt_en)); // R7

  AST_UPPER_GATED: assert property (@(posedge clk) disable iff (!started_q)
    (clr_n && ld_n && cnt_en && (count[SLICE_W-1:0] != {SLICE_W{1'b1}}))
      |=> $stable(count[CNT_W-1:SLICE_W])); // R8

endmodule

bind cascade_counter cascade_counter_chk #(.CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_chk (
  .clk        (clk),
  .clr_n      (clr_n),
  .ld_n       (ld_n),
  .load_val   (load_val),
  .cnt_en     (cnt_en),
  .count      (count),
  .term_carry (term_carry)
);

// File: tb/cascade_counter_tb.sv
module cascade_counter_tb;

  typedef struct packed {
    logic       clr_n;
    logic       ld_n;
    logic       en;
    logic [7:0] val;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00},  // R1 clear
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h01},  // R5
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h02},  // R5
    '{1'b1, 1'b1, 1'b0, 8'h00, 8'h02},  // R6 hold
    '{1'b1, 1'b0, 1'b1, 8'h0E, 8'h0E},  // R3 R4 load beats count
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h0F},  // R5
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h10},  // R8 carry into upper slice
    '{1'b1, 1'b0, 1'b0, 8'hFE, 8'hFE},  // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFF},  // R7 carry high
    '{1'b1, 1'b1, 1'b0, 8'h00, 8'hFF},  // R7 carry low without enable
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h00},  // R9 wrap
    '{1'b0, 1'b0, 1'b1, 8'h55, 8'h00},  // R2 clear beats load
    '{1'b1, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'hA6},  // R5
    '{1'b0, 1'b1, 1'b1, 8'h00, 8'h00}   // R1
  };

  logic       clk = 1'b0;
  logic       clr_n = 1'b1;
  logic       ld_n = 1'b1;
  logic [7:0] load_val = 8'h00;
  logic       cnt_en = 1'b0;
  logic [7:0] count;
  logic       term_carry;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] model;

  always #5 clk = ~clk;

  cascade_counter u_dut (
    .clk        (clk),
    .clr_n      (clr_n),
    .ld_n       (ld_n),
    .load_val   (load_val),
    .cnt_en     (cnt_en),
    .count      (count),
    .term_carry (term_carry)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic e, input logic [7:0] v);
    @(negedge clk);
    clr_n = c; ld_n = l; cnt_en = e; load_val = v;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // Reset state via synchronous clear (R1)
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R1 reset", count, 8'h00);
    chk("R7 reset carry", {7'd0, term_carry}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].clr_n, VECS[i].ld_n, VECS[i].en, VECS[i].val);
      chk($sformatf("vec%0d count", i), count, VECS[i].exp);
      chk($sformatf("R7 vec%0d carry", i), {7'd0, term_carry},
          {7'd0, (VECS[i].exp == 8'hFF) && VECS[i].en});
    end

    // R4: load at 255 with full carry chain active
    drive(1'b1, 1'b0, 1'b0, 8'hFF);
    drive(1'b1, 1'b0, 1'b1, 8'h3C);
    chk("R4 load at 255", count, 8'h3C);

    // R10: control changes between edges leave count alone
    drive(1'b1, 1'b0, 1'b0, 8'h77);
    @(negedge clk);
    clr_n = 1'b0;
    #2;
    chk("R10 clear mid-cycle", count, 8'h77);
    clr_n = 1'b1; ld_n = 1'b0; load_val = 8'h12;
    #2;
    chk("R10 load mid-cycle", count, 8'h77);
    @(posedge clk);
    #2;
    chk("R10 load at edge", count, 8'h12);

    // R5 R8 R9: long run with a gapped enable against a model
    drive(1'b1, 1'b0, 1'b0, 8'hE8);
    model = 8'hE8;
    for (int i = 0; i < 300; i++) begin
      logic e;
      logic [3:0] hi_before;
      e = (i % 3) != 2;
      hi_before = model[7:4];
      drive(1'b1, 1'b1, e, 8'h00);
      if (e) model = model + 8'd1;
      chk("R5 R9 run", count, model);
      if (model[3:0] != 4'h0 || !e)
        chk("R8 upper stable", {4'd0, count[7:4]}, {4'd0, hi_before});
      chk("R7 run carry", {7'd0, term_carry}, {7'd0, (model == 8'hFF) && e});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule